// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block gives each core of a multi-core cluster its own small set of interrupt registers, all behind one 32-bit register bus. Every bus access carries a requester core ID as a sideband, and that ID picks which core's set the access reaches. Each set holds a pending-status word, an enable word, a write-one-to-set port, a write-one-to-clear port and a bank of mailbox words. The block drives one interrupt line per core.

A core signals another core by writing the send register. The written word names a target core and a 5-bit vector, and the block turns it into a set-port write of a single bit on the target. The interrupt line has a deliberately asymmetric rule. It is raised by a set operation that leaves an enabled bit pending. It is dropped only by a clear operation that leaves status fully empty while enable is nonzero. Writing enable alone never moves the line.

Top module: `ipi_bank`

## Requirements
- R1: After reset every status, enable and mailbox word reads 0 and every interrupt output is low.
- R2: A write to the set port (offset 0x08) ORs the write data into the selected core's status. If the resulting status ANDed with enable is nonzero, that core's interrupt goes high at the same clock edge. Reads of the set port and of the clear port (0x0C) return 0.
- R3: A write to the clear port (0x0C) clears the status bits written as one. The interrupt goes low only when the resulting status is zero and enable is nonzero; in any other case it keeps its level.
- R4: A write to the enable register (offset 0x04) stores the word and reads back unchanged. An enable write alone never changes the interrupt output.
- R5: The status register (offset 0x00) is read-only, and writing it has no effect.
- R6: Mailbox words sit at the word-aligned offsets 0x20 to 0x3C. Word k is at 0x20 + 4k, so its index is (offset - 0x20) >> 2. Each core has its own words, and they read back what was written.
- R7: The requester core ID (`bus_core`) selects the register set. An ID at or above NUM_CORES reaches nothing: its writes change no state and its reads return 0.
- R8: A write to the send register (offset 0x40) takes the target core ID from data bits 25:16 and the vector from bits 4:0. It acts as a set-port write of (1 << vector) on the target core, with no error, whatever the requester.
- R9: A send naming a target ID at or above NUM_CORES gives `bus_err` = 1 in the response and changes no state. No other access gives an error.
- R10: Only address bits 7:0 are decoded. Upper address bits are ignored.
- R11: Offsets that are not defined, and the send register, read as 0. Writes to undefined offsets have no effect.
- R12: Every access gets `bus_ack` high in the cycle after it is presented, with the read data (0 for writes) and `bus_err` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address; only bits 7:0 decoded |
| bus_core | input | 10 | Requester core ID |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response strobe, one cycle after the access |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_err | output | 1 | Decode error for a send to a missing core |
| irq | output | NUM_CORES | One interrupt line per core |

## Verification
The hardest state to reach is an interrupt line that stays high while status is already empty. From the ports, the stimulus gets there by raising a core's line, then zeroing its enable word, then clearing the pending bit: status drops to zero while the line holds. Writing a nonzero enable then brings no change, and only a later clear write (even one of zero) lowers the line. Sends are aimed both at a core other than the requester and at a core ID just past the last one, so that both the cross-core set path and the error path can be seen.

// File: rtl/ipi_pkg.sv
// Package: shared register offsets and the decoded register kind for the
// inter-processor interrupt bank. Assumes an 8-bit decoded offset.
package ipi_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STATUS,
        RK_ENABLE,
        RK_SET,
        RK_CLEAR,
        RK_MBOX,
        RK_SEND
    } reg_kind_t;

    localparam logic [7:0] OFF_STATUS  = 8'h00;
    localparam logic [7:0] OFF_ENABLE  = 8'h04;
    localparam logic [7:0] OFF_SET     = 8'h08;
    localparam logic [7:0] OFF_CLEAR   = 8'h0C;
    localparam logic [7:0] OFF_MBOX_LO = 8'h20;
    localparam logic [7:0] OFF_SEND    = 8'h40;

endpackage

// File: rtl/ipi_decode.sv
// Module: ipi_decode
// Turns the low 8 bits of a bus address into a register kind and a mailbox
// word index. Assumes word-aligned mailbox words from OFF_MBOX_LO upward;
// anything unmatched decodes to RK_NONE.
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int MBOX_WORDS = 8,
    localparam int MBOX_IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
    input  logic [7:0]            offset,
    output reg_kind_t             kind,
    output logic [MBOX_IDX_W-1:0] mbox_idx
);
    localparam int MBOX_LO  = int'(OFF_MBOX_LO);
    localparam int MBOX_END = MBOX_LO + 4 * MBOX_WORDS;

    logic [7:0] mbox_rel;

    // Relative byte offset into the mailbox area.
    assign mbox_rel = offset - OFF_MBOX_LO;

    // Classify the offset into one register kind.
    always_comb begin
        kind     = RK_NONE;
        mbox_idx = mbox_rel[MBOX_IDX_W+1:2];
        if (offset == OFF_STATUS)      kind = RK_STATUS;
        else if (offset == OFF_ENABLE) kind = RK_ENABLE;
        else if (offset == OFF_SET)    kind = RK_SET;
        else if (offset == OFF_CLEAR)  kind = RK_CLEAR;
        else if (offset == OFF_SEND)   kind = RK_SEND;
        else if (int'(offset) >= MBOX_LO && int'(offset) < MBOX_END
                 && offset[1:0] == 2'b00)
            kind = RK_MBOX;
    end
endmodule

// File: rtl/ipi_core_regs.sv
// Module: ipi_core_regs
// One core's register set: status, enable, mailbox words and the interrupt
// flop. The interrupt rises on a set that leaves an enabled bit pending and
// falls only on a clear that empties status while enable is nonzero.
// Assumes at most one of set_op, clr_op, en_we, mbox_we per cycle.
module ipi_core_regs #(
    parameter int DATA_W     = 32,
    parameter int MBOX_WORDS = 8,
    localparam int MBOX_IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_op,
    input  logic                  clr_op,
    input  logic [DATA_W-1:0]     op_mask,
    input  logic                  en_we,
    input  logic                  mbox_we,
    input  logic [MBOX_IDX_W-1:0] mbox_idx,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     status_o,
    output logic [DATA_W-1:0]     enable_o,
    output logic [DATA_W-1:0]     mbox_rdata,
    output logic                  irq_o
);
    logic [DATA_W-1:0] status_q, status_nxt, enable_q;
    logic [DATA_W-1:0] mbox_q [MBOX_WORDS];
    logic              irq_q;

    // Next status after a set or clear operation.
    always_comb begin
        status_nxt = status_q;
        if (set_op)      status_nxt = status_q | op_mask;
        else if (clr_op) status_nxt = status_q & ~op_mask;
    end

    // Status and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_nxt;
            if (en_we) enable_q <= wdata;
        end
    end

    // Interrupt level: raised by set, lowered only by an emptying clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (set_op && (status_nxt & enable_q) != '0) begin
            irq_q <= 1'b1;
        end else if (clr_op && status_nxt == '0 && enable_q != '0) begin
            irq_q <= 1'b0;
        end
    end

    // Mailbox word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MBOX_WORDS; k++) mbox_q[k] <= '0;
        end else if (mbox_we) begin
            mbox_q[mbox_idx] <= wdata;
        end
    end

    assign status_o   = status_q;
    assign enable_o   = enable_q;
    assign mbox_rdata = mbox_q[mbox_idx];
    assign irq_o      = irq_q;

    // R2: the line only rises after a set operation.
    assert_irq_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(set_op));

    // R3: the line only falls after a clear that left status empty.
    assert_irq_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> ($past(clr_op) && status_q == '0));

    // R4: an enable write alone never moves the line.
    assert_en_no_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_we) |-> $stable(irq_q));

    // R5: status changes only through set or clear operations.
    assert_status_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(set_op) && !$past(clr_op)) |-> $stable(status_q));
endmodule

// File: rtl/ipi_bank.sv
// Module: ipi_bank
// Inter-processor interrupt bank with one register set per core, selected
// by the requester ID on each access. Decodes address bits 7:0 only, routes
// send-register writes into the target core's set path, and answers every
// access one cycle later. Assumes NUM_CORES >= 1 and one access per cycle.
module ipi_bank
    import ipi_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 16,
    parameter int ID_W       = 10,
    parameter int MBOX_WORDS = 8,
    parameter int VEC_W      = 5,
    parameter int TGT_LSB    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [ID_W-1:0]      bus_core,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_ack,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_err,
    output logic [NUM_CORES-1:0] irq
);
    localparam int MBOX_IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;
    localparam logic [ID_W-1:0] CORE_LIMIT = ID_W'(NUM_CORES);

    if (NUM_CORES < 1) begin : g_bad_cfg
        $error("ipi_bank: NUM_CORES must be at least 1");
    end

    reg_kind_t             kind;
    logic [MBOX_IDX_W-1:0] mbox_idx;
    logic                  req_hit, is_wr, send_wr, send_ok;
    logic [ID_W-1:0]       send_tgt;
    logic [DATA_W-1:0]     set_mask, rd_val;
    logic [DATA_W-1:0]     st_w [NUM_CORES];
    logic [DATA_W-1:0]     en_w [NUM_CORES];
    logic [DATA_W-1:0]     mb_w [NUM_CORES];

    ipi_decode #(.MBOX_WORDS(MBOX_WORDS)) u_decode (
        .offset   (bus_addr[7:0]),
        .kind     (kind),
        .mbox_idx (mbox_idx)
    );

    // Request qualifiers and the send-register fields.
    assign req_hit  = bus_valid && (bus_core < CORE_LIMIT);
    assign is_wr    = req_hit && bus_write;
    assign send_wr  = bus_valid && bus_write && (kind == RK_SEND);
    assign send_tgt = bus_wdata[TGT_LSB +: ID_W];
    assign send_ok  = send_tgt < CORE_LIMIT;
    assign set_mask = (kind == RK_SEND) ? (DATA_W'(1) << bus_wdata[VEC_W-1:0])
                                        : bus_wdata;

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        logic own, set_i, clr_i, en_i, mb_i;

        // Per-core strobes from the requester path and the send path.
        assign own   = is_wr && (bus_core == ID_W'(i));
        assign set_i = (own && kind == RK_SET)
                     || (send_wr && send_ok && send_tgt == ID_W'(i));
        assign clr_i = own && kind == RK_CLEAR;
        assign en_i  = own && kind == RK_ENABLE;
        assign mb_i  = own && kind == RK_MBOX;

        ipi_core_regs #(.DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_op     (set_i),
            .clr_op     (clr_i),
            .op_mask    (set_mask),
            .en_we      (en_i),
            .mbox_we    (mb_i),
            .mbox_idx   (mbox_idx),
            .wdata      (bus_wdata),
            .status_o   (st_w[i]),
            .enable_o   (en_w[i]),
            .mbox_rdata (mb_w[i]),
            .irq_o      (irq[i])
        );
    end

    // Read mux over the requester's register set.
    always_comb begin
        rd_val = '0;
        if (req_hit && !bus_write) begin
            for (int i = 0; i < NUM_CORES; i++) begin
                if (bus_core == ID_W'(i)) begin
                    case (kind)
                        RK_STATUS: rd_val = st_w[i];
                        RK_ENABLE: rd_val = en_w[i];
                        RK_MBOX:   rd_val = mb_w[i];
                        default:   rd_val = '0;
                    endcase
                end
            end
        end
    end

    // Registered response one cycle after each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_ack   <= bus_valid;
            bus_rdata <= rd_val;
            bus_err   <= send_wr && !send_ok;
        end
    end

    // R9: an error answers only a write to the send register.
    assert_err_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_valid && bus_write && bus_addr[7:0] == OFF_SEND));

    // R7: reads from a core ID past the last core return zero.
    assert_bad_core_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_valid && !bus_write && bus_core >= CORE_LIMIT)
        |-> bus_rdata == '0);

    // R12: a response strobe always follows a presented access.
    assert_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_valid));
endmodule

// File: tb/ipi_bank_bench.sv
// Directed bench for ipi_bank with four cores.
module ipi_bank_bench;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [9:0]  bus_core = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic [NC-1:0] irq;

    int n_checks = 0, n_errs = 0;
    bit done = 1'b0;
    logic [31:0] r_data;
    logic        r_err, r_ack;

    always #10 clk = ~clk;   // 50 MHz

    ipi_bank #(.NUM_CORES(NC)) u_ipi_bank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_core(bus_core), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input int core, input logic [15:0] addr,
                          input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_core = 10'(core);
        bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        r_data = bus_rdata; r_err = bus_err; r_ack = bus_ack;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr(input int core, input logic [15:0] addr, input logic [31:0] data);
        access(1'b1, core, addr, data);
    endtask

    task automatic rd_chk(input string tag, input int core, input logic [15:0] addr,
                          input logic [31:0] exp);
        access(1'b0, core, addr, 32'h0);
        chk(tag, r_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", 32'(irq), 32'h0);
        rd_chk("R1 status", 0, 16'h00, 32'h0);
        rd_chk("R1 enable", 1, 16'h04, 32'h0);
        rd_chk("R1 mailbox", 3, 16'h3C, 32'h0);
    endtask

    task automatic t_set_clear();
        wr(0, 16'h04, 32'h0000_000F);
        chk("R4 enable write leaves irq", 32'(irq[0]), 32'h0);
        rd_chk("R4 enable readback", 0, 16'h04, 32'h0000_000F);
        wr(0, 16'h08, 32'h0000_0030);
        chk("R2 disabled bits no irq", 32'(irq[0]), 32'h0);
        wr(0, 16'h08, 32'h0000_0001);
        chk("R2 enabled bit raises irq", 32'(irq[0]), 32'h1);
        rd_chk("R2 status OR", 0, 16'h00, 32'h0000_0031);
        rd_chk("R2 set port reads zero", 0, 16'h08, 32'h0);
        rd_chk("R2 clear port reads zero", 0, 16'h0C, 32'h0);
        wr(0, 16'h0C, 32'h0000_0001);
        chk("R3 nonempty clear holds irq", 32'(irq[0]), 32'h1);
        rd_chk("R3 status after clear", 0, 16'h00, 32'h0000_0030);
        wr(0, 16'h0C, 32'h0000_0030);
        chk("R3 emptying clear lowers irq", 32'(irq[0]), 32'h0);
    endtask

    task automatic t_sticky();
        wr(1, 16'h08, 32'h0000_0004);
        chk("R2 enable zero no irq", 32'(irq[1]), 32'h0);
        wr(1, 16'h04, 32'h0000_0004);
        chk("R4 enable does not raise", 32'(irq[1]), 32'h0);
        wr(1, 16'h08, 32'h0000_0004);
        chk("R2 re-set raises", 32'(irq[1]), 32'h1);
        wr(1, 16'h04, 32'h0);
        wr(1, 16'h0C, 32'h0000_0004);
        chk("R3 clear with enable zero holds", 32'(irq[1]), 32'h1);
        wr(1, 16'h04, 32'h0000_0001);
        chk("R4 enable write keeps high", 32'(irq[1]), 32'h1);
        wr(1, 16'h0C, 32'h0);
        chk("R3 empty clear lowers", 32'(irq[1]), 32'h0);
    endtask

    task automatic t_status_ro();
        wr(2, 16'h00, 32'hFFFF_FFFF);
        rd_chk("R5 status ignores write", 2, 16'h00, 32'h0);
    endtask

    task automatic t_mbox();
        for (int k = 0; k < 8; k++) wr(2, 16'(16'h20 + 4 * k), 32'hA000_0000 + 32'(k));
        for (int k = 0; k < 8; k++) wr(3, 16'(16'h20 + 4 * k), 32'h5B00_0000 + 32'(k));
        for (int k = 0; k < 8; k++)
            rd_chk("R6 core2 mailbox", 2, 16'(16'h20 + 4 * k), 32'hA000_0000 + 32'(k));
        rd_chk("R6 core3 mailbox", 3, 16'h2C, 32'h5B00_0003);
        rd_chk("R7 core0 mailbox untouched", 0, 16'h24, 32'h0);
    endtask

    task automatic t_steer();
        wr(7, 16'h04, 32'h0000_00FF);
        wr(7, 16'h08, 32'h0000_00FF);
        chk("R7 bad requester no irq", 32'(irq), 32'h0);
        rd_chk("R7 bad requester reads zero", 7, 16'h20, 32'h0);
        rd_chk("R7 core0 enable kept", 0, 16'h04, 32'h0000_000F);
    endtask

    task automatic t_send();
        wr(3, 16'h04, 32'h8000_0000);
        wr(1, 16'h40, (32'd3 << 16) | 32'h0000_14BF);
        chk("R8 send no error", 32'(r_err), 32'h0);
        chk("R8 send raises target irq", 32'(irq), 32'h8);
        rd_chk("R8 target status bit", 3, 16'h00, 32'h8000_0000);
        rd_chk("R8 requester status untouched", 1, 16'h00, 32'h0);
        rd_chk("R11 send reads zero", 1, 16'h40, 32'h0);
        wr(2, 16'h40, (32'd2 << 16) | 32'd5);
        rd_chk("R8 send to self", 2, 16'h00, 32'h0000_0020);
    endtask

    task automatic t_send_bad();
        wr(0, 16'h40, (32'd4 << 16) | 32'd0);
        chk("R9 missing target error", 32'(r_err), 32'h1);
        chk("R9 no irq change", 32'(irq), 32'h8);
        rd_chk("R9 core0 status unchanged", 0, 16'h00, 32'h0);
        chk("R9 no error on read", 32'(r_err), 32'h0);
    endtask

    task automatic t_alias_undef();
        wr(0, 16'h3304, 32'h0000_0055);
        rd_chk("R10 upper bits ignored", 0, 16'h0004, 32'h0000_0055);
        rd_chk("R10 aliased read", 0, 16'hFF04, 32'h0000_0055);
        wr(0, 16'h10, 32'hFFFF_FFFF);
        wr(0, 16'h44, 32'hFFFF_FFFF);
        rd_chk("R11 undefined reads zero", 0, 16'h10, 32'h0);
        rd_chk("R11 undefined write ignored", 0, 16'h04, 32'h0000_0055);
        rd_chk("R11 status after undefined", 0, 16'h00, 32'h0);
    endtask

    task automatic t_timing();
        access(1'b0, 0, 16'h04, 32'h0);
        chk("R12 ack with read", 32'(r_ack), 32'h1);
        chk("R12 data with ack", r_data, 32'h0000_0055);
        @(negedge clk);
        chk("R12 ack idle", 32'(bus_ack), 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_sticky();
        t_status_ro();
        t_mbox();
        t_steer();
        t_send();
        t_send_bad();
        t_alias_undef();
        t_timing();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule